// File: doc/BRIEF.md
# Multi-Lane Aligned Pattern Transmitter

This block feeds four parallel serializer lanes with a repeating, random-looking test pattern. One address counter, running on the parallel-domain clock, walks a read-only pattern store whose words are 40 bits wide. Every word is split into four 10-bit symbols, one for each lane. All lanes therefore come from the same counter, and their relative timing cannot drift. A reset or a pause leaves no offset between them.

The length of one pattern cycle is set by the parameter `CYC_LOG` (written n below). A cycle holds 2^(n-3) words, which is 10 × 2^(n-3) bits per lane. A one-clock strobe marks the clock in which the final word of each cycle is on the lanes. A test setup uses this strobe to trigger a scope or to frame captured data. The `en_i` input pauses the stream without losing its position.

Top module: `multilane_pattern_tx`

## Requirements
- R1: A synchronous, active-high `rst_i` sampled at a clock edge drives all four lane buses and `cycle_done_o` to 0 and returns the pattern position to word 0.
- R2: On the first enabled clock after reset is released, all four lanes present their slices of word 0 together.
- R3: Each clock with `en_i` high presents the next word. After word DEPTH-1 comes word 0, where DEPTH = 2^(CYC_LOG-3).
- R4: `cycle_done_o` is high exactly in the clocks where word DEPTH-1 is presented. Consecutive pulses are separated by DEPTH enabled clocks.
- R5: While `en_i` is low, the lane buses hold their last value and `cycle_done_o` is 0. When `en_i` returns high, the stream continues with the word after the last one shown.
- R6: The content of word i is produced by a 16-bit right-shifting Galois LFSR with seed 16'hACE1 and toggle mask 16'hB400. Each step outputs bit 0 of the state, shifts the state right by one, and XORs the mask into the state if the output bit was 1. Word i is made of steps 40·i to 40·i+39, with the first of these steps in bit 0.
- R7: Lane k (k = 0..3) carries bits [10k+9:10k] of the same word in the same clock. The inter-lane offset is zero after every reset and pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel-domain clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the pattern when high, hold when low |
| lane0_o | output | 10 | Lane 0 symbol, word bits [9:0] |
| lane1_o | output | 10 | Lane 1 symbol, word bits [19:10] |
| lane2_o | output | 10 | Lane 2 symbol, word bits [29:20] |
| lane3_o | output | 10 | Lane 3 symbol, word bits [39:30] |
| cycle_done_o | output | 1 | One-clock pulse with the last word of each cycle |

## Verification
The assertions assume that `rst_i` and `en_i` are synchronous to `clk_i` and settle well before each rising edge. They also assume that reset is applied at the first edges, before any position is meaningful. The stimulus changes both inputs only on falling edges. It holds reset high from time zero. It then mixes long enabled runs, single-cycle pauses, multi-cycle pauses, and resets that arrive in the middle of a cycle or while the block is paused.

// File: rtl/pattgen_pkg.sv
package pattgen_pkg;

  localparam int LANES      = 4;
  localparam int SYM_W      = 10;
  localparam int WORD_W     = LANES * SYM_W;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_MASK = 16'hB400;

  // Content of pattern word idx: 40 consecutive LFSR output bits, earliest in bit 0.
  function automatic logic [WORD_W-1:0] pat_word(input int idx);
    logic [15:0]       st;
    logic [WORD_W-1:0] w;
    logic              ob;
    st = LFSR_SEED;
    w  = '0;
    for (int k = 0; k <= idx; k++) begin
      for (int b = 0; b < WORD_W; b++) begin
        ob   = st[0];
        st   = st >> 1;
        if (ob) st = st ^ LFSR_MASK;
        w[b] = ob;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/lane_addr_ctr.sv
module lane_addr_ctr #(
  parameter int AW    = 5,
  parameter int DEPTH = 32
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  assign last_o = (addr_q == LAST);
  assign addr_o = addr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       addr_q <= '0;
    else if (en_i)   addr_q <= last_o ? '0 : addr_q + 1'b1;
  end

  // R3: an enabled clock moves the shared address forward by exactly one, wrapping after LAST
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + 1'b1)));

  // R5: a disabled clock leaves the address untouched
  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(addr_q));

endmodule

// File: rtl/pattern_rom.sv
module pattern_rom
  import pattgen_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [AW-1:0]     addr_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] rom_w [DEPTH];
  logic [WORD_W-1:0] word_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [WORD_W-1:0] CONTENT = pat_word(g);
    assign rom_w[g] = CONTENT;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     word_q <= '0;
    else if (en_i) word_q <= rom_w[addr_i];
  end

  assign word_o = word_q;

  // R5: the registered word is frozen across any disabled clock
  p_word_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(word_q));

endmodule

// File: rtl/lane_fanout.sv
module lane_fanout
  import pattgen_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [SYM_W-1:0]  lane_o [LANES]
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_o[k] = word_i[k*SYM_W +: SYM_W];
  end

endmodule

// File: rtl/multilane_pattern_tx.sv
module multilane_pattern_tx
  import pattgen_pkg::*;
#(
  parameter int CYC_LOG = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic [SYM_W-1:0] lane0_o,
  output logic [SYM_W-1:0] lane1_o,
  output logic [SYM_W-1:0] lane2_o,
  output logic [SYM_W-1:0] lane3_o,
  output logic             cycle_done_o
);

  localparam int DEPTH = 1 << (CYC_LOG - 3);
  localparam int AW    = (CYC_LOG > 3) ? (CYC_LOG - 3) : 1;

  if (CYC_LOG < 3) begin : g_bad_cfg
    $error("CYC_LOG must be at least 3");
  end

  logic [AW-1:0]     addr_w;
  logic              last_w;
  logic [WORD_W-1:0] word_w;
  logic [SYM_W-1:0]  lanes_w [LANES];
  logic              done_q;

  lane_addr_ctr #(.AW(AW), .DEPTH(DEPTH)) u_ctr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .addr_o(addr_w),
    .last_o(last_w)
  );

  pattern_rom #(.AW(AW), .DEPTH(DEPTH)) u_rom (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .addr_i(addr_w),
    .word_o(word_w)
  );

  lane_fanout u_fan (
    .word_i(word_w),
    .lane_o(lanes_w)
  );

  // Registered alongside the ROM read so the strobe lines up with the last word.
  always_ff @(posedge clk_i) begin
    if (rst_i) done_q <= 1'b0;
    else       done_q <= en_i & last_w;
  end

  assign lane0_o      = lanes_w[0];
  assign lane1_o      = lanes_w[1];
  assign lane2_o      = lanes_w[2];
  assign lane3_o      = lanes_w[3];
  assign cycle_done_o = done_q;

  // R4: the strobe coincides with the counter having just wrapped to word 0
  p_done_at_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    cycle_done_o |-> (addr_w == '0));

  // R4: the strobe is a single-clock pulse when a cycle holds more than one word
  if (DEPTH > 1) begin : g_pulse_chk
    p_done_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      cycle_done_o |=> !cycle_done_o);
  end

  // R5: pausing freezes every lane and silences the strobe
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable({lane3_o, lane2_o, lane1_o, lane0_o}) && !cycle_done_o));

endmodule

// File: tb/tb_multilane_pattern_tx.sv
module tb_multilane_pattern_tx;

  localparam int CYC_LOG = 8;
  localparam int DEPTH   = 1 << (CYC_LOG - 3);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [9:0] l0, l1, l2, l3;
  logic       done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;   // 50 MHz

  multilane_pattern_tx #(.CYC_LOG(CYC_LOG)) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .lane0_o(l0), .lane1_o(l1), .lane2_o(l2), .lane3_o(l3),
    .cycle_done_o(done)
  );

  // Expected pattern, built as one continuous LFSR bit stream.
  logic [39:0] exp_mem [DEPTH];
  initial begin
    logic [15:0] s;
    logic [39:0] acc;
    logic        bitv;
    s = 16'hACE1;
    for (int i = 0; i < DEPTH; i++) begin
      acc = '0;
      for (int b = 0; b < 40; b++) begin
        bitv = s[0];
        s    = {1'b0, s[15:1]} ^ (bitv ? 16'hB400 : 16'h0000);
        acc  = {bitv, acc[39:1]};
      end
      exp_mem[i] = acc;
    end
  end

  // Scoreboard queues.
  logic [39:0] q_word [$];
  logic        q_done [$];
  logic        q_en   [$];
  logic        q_rst  [$];
  string       q_tag  [$];

  // Reference model state.
  int          m_pos  = 0;
  logic [39:0] m_word = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [39:0] got, input logic [39:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Driver: set inputs on the falling edge and queue what the next rising edge must produce.
  task automatic step(input logic r, input logic e, input string tag);
    logic d;
    @(negedge clk);
    rst = r;
    en  = e;
    d   = 1'b0;
    if (r) begin
      m_pos  = 0;
      m_word = '0;
    end else if (e) begin
      m_word = exp_mem[m_pos];
      d      = (m_pos == DEPTH - 1);
      m_pos  = (m_pos + 1) % DEPTH;
    end
    q_word.push_back(m_word);
    q_done.push_back(d);
    q_en.push_back(e);
    q_rst.push_back(r);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge.
  int  en_since_done = 0;
  bit  seen_done     = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #1ns;
      if (q_word.size() > 0) begin
        logic [39:0] w;
        logic        d, e, r;
        string       tag;
        logic [39:0] got;
        w = q_word.pop_front();
        d = q_done.pop_front();
        e = q_en.pop_front();
        r = q_rst.pop_front();
        tag = q_tag.pop_front();
        got = {l3, l2, l1, l0};
        for (int k = 0; k < 4; k++)
          check(got[k*10 +: 10] == w[k*10 +: 10], tag, $sformatf("lane%0d R7", k),
                40'(got[k*10 +: 10]), 40'(w[k*10 +: 10]));
        check(done == d, tag, "cycle_done R4", 40'(done), 40'(d));
        // R4: pulse spacing measured in enabled clocks
        if (r) begin
          seen_done     = 1'b0;
          en_since_done = 0;
        end else begin
          if (e) en_since_done++;
          if (done) begin
            if (seen_done)
              check(en_since_done == DEPTH, "R4", "done period",
                    40'(en_since_done), 40'(DEPTH));
            seen_done     = 1'b1;
            en_since_done = 0;
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset from time zero clears lanes and strobe
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1");
    // R2: first enabled clock shows word 0
    step(1'b0, 1'b1, "R2");
    // R3, R6: two full cycles plus a few words, wrap included
    for (int i = 0; i < 2 * DEPTH + 3; i++) step(1'b0, 1'b1, "R3");
    // R5: pauses of several lengths
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R5");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, "R5");
    for (int i = 0; i < DEPTH; i++) step(1'b0, (i % 3) != 1, "R5");
    // pause across the wrap point
    while (m_pos != DEPTH - 1) step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R3");
    // R7: reset in the middle of a cycle, restart aligned
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < DEPTH + 4; i++) step(1'b0, 1'b1, "R7");
    // reset while paused, release still paused
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R2");
    for (int i = 0; i < 2 * DEPTH; i++) step(1'b0, 1'b1, "R7");
    // drain
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule